// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frames from a byte stream into memory. It works through a circular list of descriptors, each of which is four 32-bit words. Starting at a base address, it reads the parameter word, the link to the next descriptor, the buffer pointer and the status word. It then waits for a frame, packs the frame's bytes into 32-bit words and writes them into the buffer. When the frame ends, it writes a completion status back into the descriptor and follows the link to the next one.

Software controls the handover through two bits. A descriptor is skipped while its parameter word carries the hold flag. It is also skipped while its status word still shows an earlier completion. In both cases the engine polls the descriptor again and does not take any input bytes. A single request/grant memory port carries all reads and writes, with at most one operation in flight. Read data comes back on a separate valid strobe.

Top module: `rxd_ring_dma`

## Requirements
- R1: While reset is active, and afterwards until `enable` is raised, `mem_req` and `in_ready` stay low.
- R2: When `enable` is seen high while the engine is idle, it loads `ring_base` and reads that descriptor's words in order at offsets +0, +4, +8 and +12. Every address it issues is word aligned.
- R3: If bit 31 (hold) of the parameter word is set, the descriptor is not used. The engine reads the parameter word again and takes no input bytes until the bit is clear.
- R4: If bit 31 (complete) of the status word is set when it is fetched, no bytes are taken. The engine fetches the descriptor again from +0.
- R5: Frame byte k goes to byte lane k mod 4 (bits 8·lane+7..8·lane) of the word at buffer + 4·offset + 4·(k div 4). The offset is parameter bits 28:26 and counts words. A partial last word is written with only its filled lanes enabled.
- R6: While the engine waits for a frame, bytes without `in_sop` are accepted and discarded.
- R7: On frame end, the engine writes the status word at +12 with all four lanes enabled. The word holds bit 31 = 1, bit 30 = 1, bit 29 = 1 and the count of accepted bytes in bits 16:0. All other bits are zero. The count includes the trailing check bytes.
- R8: The maximum buffer size is parameter bits 21:0. Bytes beyond it are accepted but not stored, the count equals that size, and status bit 29 is written as 0. A frame of exactly that size is not truncated.
- R9: After a status write, the next descriptor fetched is the one at the link word (+4), so the list wraps through its own links.
- R10: A request keeps its address, direction, data and lane enables until granted. Only one operation is outstanding at a time. `in_ready` is low whenever a write is being requested.
- R11: When `enable` is low, the engine goes idle at the next descriptor boundary and issues no requests. Raising it again reloads `ring_base`.
- R12: The interrupt-enable bits 30:29 of the parameter word have no effect on the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control |
| ring_base | input | AW | Address of the first descriptor, sampled when starting |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write lane enables |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_ready | output | 1 | Input byte accepted when high with `in_valid` |

## Verification
The bench runs frames of 9, 6, 4, 11 and 5 bytes through a three-descriptor ring while the grant pattern varies from cycle to cycle. It holds one descriptor with the hold flag and finds another still marked complete. An engine that ignored either flag would write into a buffer software still owns. The truncation case and the exact-size case sit side by side on the same 5-byte descriptor. Getting that boundary off by one would either lose a byte or drop the end flag on a frame that fits. Stray bytes before the frame start, a word offset, and a partial final word expose packing errors in the byte lanes. Disabling and then re-enabling with a different base shows whether the start address is really reloaded.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  // descriptor word byte offsets (fetch order matters)
  localparam int OFS_PARAM = 0;
  localparam int OFS_LINK  = 4;
  localparam int OFS_BUF   = 8;
  localparam int OFS_STAT  = 12;

  // parameter word fields
  localparam int P_HOLD   = 31;
  localparam int P_SKIP_H = 28;
  localparam int P_SKIP_L = 26;

  // status word fields
  localparam int S_DONE = 31;
  localparam int S_FIRST = 30;
  localparam int S_LAST = 29;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DESC,
    ST_RD_PARAM,
    ST_RD_LINK,
    ST_RD_BUF,
    ST_RD_STAT,
    ST_WAIT_SOP,
    ST_RECV,
    ST_FLUSH,
    ST_WR_DATA,
    ST_WR_STAT
  } eng_state_t;
endpackage

// File: rtl/rxd_packer.sv
module rxd_packer
  import rxd_pkg::*;
#(
  parameter int SIZE_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic              drain_i,
  input  logic [7:0]        byte_i,
  input  logic [SIZE_W-1:0] limit_i,
  output logic [WORD_W-1:0] word_o,
  output logic [LANES-1:0]  be_o,
  output logic              full_o,
  output logic [SIZE_W-1:0] count_o,
  output logic              trunc_o
);
  localparam int LANE_W = $clog2(LANES);

  logic [WORD_W-1:0] word_q, word_d;
  logic [LANES-1:0]  be_q, be_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [SIZE_W-1:0] count_q, count_d;
  logic              trunc_q, trunc_d;
  logic              upd_en;
  logic [LANES-1:0]  lane_hit;
  logic              room;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_hit[g] = (lane_q == LANE_W'(g));
  end

  assign room   = (count_q < limit_i);
  assign upd_en = clr_i | drain_i | take_i;

  always_comb begin
    word_d  = word_q;
    be_d    = be_q;
    lane_d  = lane_q;
    count_d = count_q;
    trunc_d = trunc_q;
    if (clr_i) begin
      word_d  = '0;
      be_d    = '0;
      lane_d  = '0;
      count_d = '0;
      trunc_d = 1'b0;
    end else begin
      if (drain_i) begin
        word_d = '0;
        be_d   = '0;
        lane_d = '0;
      end
      if (take_i) begin
        if (room) begin
          for (int l = 0; l < LANES; l++) begin
            if (lane_hit[l]) begin
              word_d[l*8 +: 8] = byte_i;
              be_d[l]          = 1'b1;
            end
          end
          lane_d  = lane_q + 1'b1;
          count_d = count_q + 1'b1;
        end else begin
          trunc_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      be_q    <= '0;
      lane_q  <= '0;
      count_q <= '0;
      trunc_q <= 1'b0;
    end else if (upd_en) begin
      word_q  <= word_d;
      be_q    <= be_d;
      lane_q  <= lane_d;
      count_q <= count_d;
      trunc_q <= trunc_d;
    end
  end

  assign word_o  = word_q;
  assign be_o    = be_q;
  assign full_o  = &be_q;
  assign count_o = count_q;
  assign trunc_o = trunc_q;
endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 22,
  parameter int CNT_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [AW-1:0]     base_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic [LANES-1:0]  mem_be_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  output logic              in_ready_o,
  output logic              clr_o,
  output logic              take_o,
  output logic              drain_o,
  output logic [SIZE_W-1:0] limit_o,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANES-1:0]  be_i,
  input  logic              full_i,
  input  logic [SIZE_W-1:0] count_i,
  input  logic              trunc_i
);
  localparam int SKIP_W = P_SKIP_H - P_SKIP_L + 1;

  eng_state_t        state_q, state_d;
  logic              rd_wait_q, rd_wait_d;
  logic              en_q;
  logic [AW-1:0]     cur_q, cur_d;
  logic [AW-1:0]     link_q, link_d;
  logic [AW-1:0]     wptr_q, wptr_d;
  logic [SIZE_W-1:0] limit_q, limit_d;
  logic [SKIP_W-1:0] skip_q, skip_d;
  logic              last_q, last_d;
  logic              rd_state, rd_done;
  logic [WORD_W-1:0] stat_word;
  logic              unused_cnt_hi;

  assign unused_cnt_hi = ^count_i[SIZE_W-1:CNT_W];

  assign rd_state = (state_q == ST_RD_PARAM) || (state_q == ST_RD_LINK) ||
                    (state_q == ST_RD_BUF)   || (state_q == ST_RD_STAT);
  assign rd_done  = rd_wait_q & mem_rvalid_i;

  always_comb begin
    stat_word              = '0;
    stat_word[S_DONE]      = 1'b1;
    stat_word[S_FIRST]     = 1'b1;
    stat_word[S_LAST]      = ~trunc_i;
    stat_word[CNT_W-1:0]   = count_i[CNT_W-1:0];
  end

  always_comb begin
    state_d    = state_q;
    rd_wait_d  = rd_wait_q;
    cur_d      = cur_q;
    link_d     = link_q;
    wptr_d     = wptr_q;
    limit_d    = limit_q;
    skip_d     = skip_q;
    last_d     = last_q;
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = cur_q;
    mem_wdata_o = '0;
    mem_be_o   = '0;
    in_ready_o = 1'b0;
    clr_o      = 1'b0;
    take_o     = 1'b0;
    drain_o    = 1'b0;

    if (rd_state) begin
      mem_req_o = ~rd_wait_q;
      if (~rd_wait_q && mem_gnt_i) rd_wait_d = 1'b1;
      if (rd_done) rd_wait_d = 1'b0;
    end

    unique case (state_q)
      ST_IDLE: begin
        if (en_q) begin
          cur_d   = base_i;
          state_d = ST_DESC;
        end
      end
      ST_DESC: begin
        state_d = en_q ? ST_RD_PARAM : ST_IDLE;
      end
      ST_RD_PARAM: begin
        mem_addr_o = cur_q + AW'(OFS_PARAM);
        if (rd_done) begin
          if (mem_rdata_i[P_HOLD]) begin
            state_d = ST_DESC;
          end else begin
            limit_d = mem_rdata_i[SIZE_W-1:0];
            skip_d  = mem_rdata_i[P_SKIP_H:P_SKIP_L];
            state_d = ST_RD_LINK;
          end
        end
      end
      ST_RD_LINK: begin
        mem_addr_o = cur_q + AW'(OFS_LINK);
        if (rd_done) begin
          link_d  = mem_rdata_i[AW-1:0];
          state_d = ST_RD_BUF;
        end
      end
      ST_RD_BUF: begin
        mem_addr_o = cur_q + AW'(OFS_BUF);
        if (rd_done) begin
          wptr_d  = mem_rdata_i[AW-1:0] + AW'({skip_q, 2'b00});
          state_d = ST_RD_STAT;
        end
      end
      ST_RD_STAT: begin
        mem_addr_o = cur_q + AW'(OFS_STAT);
        if (rd_done) begin
          if (mem_rdata_i[S_DONE]) begin
            state_d = ST_DESC;
          end else begin
            clr_o   = 1'b1;
            last_d  = 1'b0;
            state_d = ST_WAIT_SOP;
          end
        end
      end
      ST_WAIT_SOP: begin
        in_ready_o = 1'b1;
        if (in_valid_i && in_sop_i) begin
          take_o = 1'b1;
          if (in_eop_i) begin
            last_d  = 1'b1;
            state_d = ST_FLUSH;
          end else begin
            state_d = ST_RECV;
          end
        end
      end
      ST_RECV: begin
        if (full_i) begin
          state_d = ST_WR_DATA;
        end else begin
          in_ready_o = 1'b1;
          if (in_valid_i) begin
            take_o = 1'b1;
            if (in_eop_i) begin
              last_d  = 1'b1;
              state_d = ST_FLUSH;
            end
          end
        end
      end
      ST_FLUSH: begin
        state_d = (be_i != '0) ? ST_WR_DATA : ST_WR_STAT;
      end
      ST_WR_DATA: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = wptr_q;
        mem_wdata_o = word_i;
        mem_be_o    = be_i;
        if (mem_gnt_i) begin
          drain_o = 1'b1;
          wptr_d  = wptr_q + AW'(LANES);
          state_d = last_q ? ST_WR_STAT : ST_RECV;
        end
      end
      ST_WR_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q + AW'(OFS_STAT);
        mem_wdata_o = stat_word;
        mem_be_o    = '1;
        if (mem_gnt_i) begin
          cur_d   = link_q;
          state_d = ST_DESC;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rd_wait_q <= 1'b0;
      en_q      <= 1'b0;
      cur_q     <= '0;
      link_q    <= '0;
      wptr_q    <= '0;
      limit_q   <= '0;
      skip_q    <= '0;
      last_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      rd_wait_q <= rd_wait_d;
      en_q      <= enable_i;
      cur_q     <= cur_d;
      link_q    <= link_d;
      wptr_q    <= wptr_d;
      limit_q   <= limit_d;
      skip_q    <= skip_d;
      last_q    <= last_d;
    end
  end

  assign limit_o = limit_q;
endmodule

// File: rtl/rxd_ring_dma.sv
module rxd_ring_dma
  import rxd_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 22,
  parameter int CNT_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [AW-1:0]     ring_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_be,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              in_ready
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              clr, take, drain, full, trunc;
  logic [SIZE_W-1:0] limit, count;
  logic [WORD_W-1:0] word;
  logic [LANES-1:0]  be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rxd_ctrl #(.AW(AW), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .enable_i     (enable),
    .base_i       (ring_base),
    .mem_req_o    (mem_req),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_be_o     (mem_be),
    .mem_gnt_i    (mem_gnt),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata),
    .in_valid_i   (in_valid),
    .in_sop_i     (in_sop),
    .in_eop_i     (in_eop),
    .in_ready_o   (in_ready),
    .clr_o        (clr),
    .take_o       (take),
    .drain_o      (drain),
    .limit_o      (limit),
    .word_i       (word),
    .be_i         (be),
    .full_i       (full),
    .count_i      (count),
    .trunc_i      (trunc)
  );

  rxd_packer #(.SIZE_W(SIZE_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr_i   (clr),
    .take_i  (take),
    .drain_i (drain),
    .byte_i  (in_data),
    .limit_i (limit),
    .word_o  (word),
    .be_o    (be),
    .full_o  (full),
    .count_o (count),
    .trunc_o (trunc)
  );
endmodule

// File: rtl/rxd_ring_dma_chk.sv
module rxd_ring_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [3:0]    mem_be,
  input logic          in_ready
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_wdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_gnt |=> $stable(mem_wdata) && $stable(mem_be));

  p_no_intake_in_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !in_ready);

  p_lanes_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != 4'b0000);

  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
endmodule

bind rxd_ring_dma rxd_ring_dma_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_gnt   (mem_gnt),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_be    (mem_be),
  .in_ready  (in_ready)
);

// File: tb/rxd_ring_dma_test.sv
module rxd_ring_dma_test;
  logic        clk = 1'b0;
  logic        rst_n, enable;
  logic [31:0] ring_base;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        in_valid, in_sop, in_eop, in_ready;
  logic [7:0]  in_data;

  always #10 clk = ~clk;

  rxd_ring_dma uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ring_base(ring_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
    .in_eop(in_eop), .in_ready(in_ready)
  );

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  be;
    string       tag;
  } wr_t;

  int          n_chk = 0, n_fail = 0, n_wr = 0, cyc = 0;
  logic [31:0] mem [int];
  wr_t         exp_q[$];
  logic [31:0] rd_log[$];
  logic        rv_pend;
  logic [31:0] rv_addr;
  logic [7:0]  lf;

  function automatic void chk(bit ok, string tag, string what,
                              logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endfunction

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model, grant pattern, write checking; all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
    if (!rst_n) begin
      mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
      rv_pend = 1'b0; lf = 8'h5a;
    end else begin
      mem_rvalid = rv_pend;
      mem_rdata  = rv_pend ? rd(rv_addr) : 32'h0;
      rv_pend    = 1'b0;
      lf         = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mem_gnt    = mem_req && (lf[0] || lf[2]);
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          logic [31:0] m, w;
          wr_t e;
          n_wr++;
          chk(!in_ready, "R10", "in_ready during write", {31'b0, in_ready}, 0);
          if (exp_q.size() == 0) begin
            chk(0, "R7", "unexpected write addr", mem_addr, 32'hx);
          end else begin
            e = exp_q.pop_front();
            m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
            if (mem_addr != e.a || mem_be != e.be)
              chk(0, e.tag, "write addr/be", {mem_addr[27:0], mem_be}, {e.a[27:0], e.be});
            else
              chk((mem_wdata & m) == (e.d & m), e.tag, "write data", mem_wdata, e.d);
          end
          w = rd(mem_addr);
          for (int b = 0; b < 4; b++) if (mem_be[b]) w[b*8 +: 8] = mem_wdata[b*8 +: 8];
          mem[mem_addr] = w;
        end else begin
          rv_pend = 1'b1;
          rv_addr = mem_addr;
          rd_log.push_back(mem_addr);
        end
      end
    end
  end

  // reference: expected writes for one frame into one descriptor
  task automatic expect_frame(int desc, int bufp, int off, int maxb,
                              byte unsigned fr[$], string dtag, string stag);
    int    s = (fr.size() > maxb) ? maxb : fr.size();
    bit    tr = fr.size() > maxb;
    wr_t   e;
    for (int w = 0; w * 4 < s; w++) begin
      e.a = bufp + 4 * off + 4 * w; e.d = 0; e.be = 0; e.tag = dtag;
      for (int l = 0; l < 4; l++) begin
        if (w * 4 + l < s) begin
          e.d[l*8 +: 8] = fr[w*4 + l];
          e.be[l] = 1'b1;
        end
      end
      exp_q.push_back(e);
    end
    e.a = desc + 12; e.be = 4'hF; e.tag = stag;
    e.d = 32'hC000_0000 | (tr ? 32'h0 : 32'h2000_0000) | s;
    exp_q.push_back(e);
  endtask

  task automatic put(logic [7:0] b, bit s, bit e);
    bit ok;
    in_valid = 1'b1; in_data = b; in_sop = s; in_eop = e;
    forever begin
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic send(byte unsigned fr[$], int junk);
    for (int j = 0; j < junk; j++) put(8'hE0 + 8'(j), 1'b0, 1'b0);
    for (int i = 0; i < fr.size(); i++) put(fr[i], i == 0, i == fr.size() - 1);
  endtask

  task automatic drain_wait();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic bit logged(logic [31:0] a);
    foreach (rd_log[i]) if (rd_log[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    byte unsigned f1[$], f2[$], f3[$], f4[$], f5[$];
    int  w0;
    bit  seen;
    rst_n = 1'b0; enable = 1'b0; ring_base = '0;
    in_valid = 1'b0; in_data = '0; in_sop = 1'b0; in_eop = 1'b0;
    for (int i = 0; i < 9;  i++) f1.push_back(8'h11 + 8'(i));
    for (int i = 0; i < 6;  i++) f2.push_back(8'h40 + 8'(i));
    for (int i = 0; i < 11; i++) f3.push_back(8'h80 + 8'(i));
    for (int i = 0; i < 4;  i++) f4.push_back(8'hA0 + 8'(i));
    for (int i = 0; i < 5;  i++) f5.push_back(8'hC0 + 8'(i));
    // three descriptors linked in a loop
    mem[32'h100] = 32'd64;                  mem[32'h104] = 32'h200;
    mem[32'h108] = 32'h1000;                mem[32'h10c] = 32'h0;
    mem[32'h200] = 32'h8000_0000 | (32'd2 << 26) | 32'd64;
    mem[32'h204] = 32'h300; mem[32'h208] = 32'h2000; mem[32'h20c] = 32'h0;
    mem[32'h300] = 32'h6000_0000 | 32'd5;   mem[32'h304] = 32'h100;
    mem[32'h308] = 32'h3000;                mem[32'h30c] = 32'h0;

    repeat (4) @(negedge clk);
    chk(!mem_req && !in_ready, "R1", "idle in reset", {mem_req, in_ready}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!mem_req && !in_ready, "R1", "idle before enable", {mem_req, in_ready}, 0);

    // frame 1: two stray bytes, 9-byte frame, desc at 0x100
    ring_base = 32'h100;
    expect_frame(32'h100, 32'h1000, 0, 64, f1, "R6", "R7");
    enable = 1'b1;
    send(f1, 2);
    drain_wait();
    for (int i = 0; i < 4; i++)
      chk(rd_log.size() > i && rd_log[i] == 32'h100 + 4 * i, "R2", "fetch order",
          rd_log.size() > i ? rd_log[i] : 32'hx, 32'h100 + 4 * i);

    // desc at 0x200 is held
    rd_log.delete(); w0 = n_wr; seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (in_ready) seen = 1; end
    chk(n_wr == w0 && !seen && logged(32'h200) && !logged(32'h204), "R3",
        "held descriptor used", {n_wr[15:0], 15'b0, seen}, {w0[15:0], 16'b0});
    mem[32'h200] = mem[32'h200] & 32'h7fff_ffff;
    expect_frame(32'h200, 32'h2000, 2, 64, f2, "R5", "R9");
    send(f2, 0);
    drain_wait();

    // desc at 0x300: limit 5, 11-byte frame, irq bits set
    expect_frame(32'h300, 32'h3000, 0, 5, f3, "R8", "R12");
    send(f3, 0);
    drain_wait();

    // wrap to 0x100 which is still complete
    rd_log.delete(); w0 = n_wr; seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (in_ready) seen = 1; end
    chk(n_wr == w0 && !seen && logged(32'h10c), "R4", "complete descriptor reused",
        {n_wr[15:0], 15'b0, seen}, {w0[15:0], 16'b0});
    mem[32'h10c] = 32'h0;
    expect_frame(32'h100, 32'h1000, 0, 64, f4, "R5", "R9");
    send(f4, 0);
    drain_wait();

    // disable, then restart at a different base
    enable = 1'b0;
    repeat (40) @(negedge clk);
    seen = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (mem_req) seen = 1; end
    chk(!seen, "R11", "request while disabled", {31'b0, seen}, 0);
    ring_base = 32'h300;
    mem[32'h30c] = 32'h0;
    rd_log.delete();
    expect_frame(32'h300, 32'h3000, 0, 5, f5, "R8", "R8");
    enable = 1'b1;
    send(f5, 0);
    drain_wait();
    chk(rd_log.size() > 0 && rd_log[0] == 32'h300, "R11", "base reload",
        rd_log.size() > 0 ? rd_log[0] : 32'hx, 32'h300);
    chk(exp_q.size() == 0, "R7", "writes missing", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule